// File: doc/BRIEF.md
# Memory Size Limit Gate

This block sits on the bus in front of a flash region and a RAM region. It hides the upper part of each region behind a limit register. The register holds two 3-bit step fields, one per region. At step N the visible part of a region is its total size divided by 2^N, counted from the region base. An active transfer into the hidden part gets the bus error response. The same response goes to an unprivileged master that touches the limit register. A blocked access therefore looks like an access to something that does not exist.

The register resets to zero, so at reset both regions are fully visible. A boot pulse then copies a configuration word from nonvolatile storage into the two fields. Privileged software can later raise either field, but it can never lower one. Each field is compared on its own, so a single write may raise one field and leave the other where it is. The block checks each address phase and flags transfers that are allowed to reach a memory. It produces the two-cycle error response itself and returns the register value on privileged reads.

Top module: `memlim_gate`

## Requirements
- R1: After reset both fields read as zero, and every address in both regions is visible with no error response.
- R2: A one-cycle `boot_ld_i` pulse loads bits 22..20 of `boot_word_i` into the flash field and bits 18..16 into the RAM field. It takes priority over a bus write in the same cycle.
- R3: A privileged write replaces a field only when its new value (flash at wdata 22..20, RAM at 18..16) is larger than the current one. Each field decides on its own, and a smaller value leaves that field unchanged.
- R4: With flash field N, an active transfer whose offset from the flash base is at least 2^FLASH_AW / 2^N gets an error. A smaller offset passes and raises `pass_o`.
- R5: With RAM field N, an active transfer whose offset from the RAM base is at least 2^RAM_AW / 2^N gets an error. A smaller offset passes and raises `pass_o`.
- R6: A read or write of the limit register with `hpriv_i` (HPROT[1]) low gets an error response and leaves the register unchanged.
- R7: A privileged read of the limit register returns the flash field at bits 22..20 and the RAM field at bits 18..16, with all other bits zero, in the data phase.
- R8: An error response lasts two data-phase cycles: first `hready_o`=0 with `hresp_o`=1, then `hready_o`=1 with `hresp_o`=1. A passed transfer shows `hready_o`=1 and `hresp_o`=0.
- R9: Only NONSEQ (`htrans_i`=2'b10) and SEQ (2'b11) transfers are checked. IDLE (2'b00) and BUSY (2'b01) never cause an error and never raise `pass_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| boot_ld_i | input | 1 | Pulse that loads the boot limit word |
| boot_word_i | input | 32 | Limit word from nonvolatile configuration |
| haddr_i | input | 32 | Address-phase address |
| htrans_i | input | 2 | Transfer type |
| hwrite_i | input | 1 | Write flag of the address phase |
| hpriv_i | input | 1 | Privileged-access protection bit (HPROT[1]) |
| hwdata_i | input | 32 | Write data, data phase |
| hready_i | input | 1 | Bus ready; an address phase is taken when high |
| hready_o | output | 1 | Ready driven by the error responder |
| hresp_o | output | 1 | Error response |
| hrdata_o | output | 32 | Limit register read data, zero otherwise |
| pass_o | output | 1 | Active transfer hits the visible part of a region |

## Verification
Directed transfers are placed one word each side of every visible boundary, at several field values. A comparator that is off by one, or a shift by the wrong step, shows up as a wrong result on one side. Register writes mix raising, lowering and reserved-bit patterns across the two fields, which separates per-field monotonic update from a whole-word compare. Unprivileged accesses and IDLE/BUSY transfers aimed at hidden addresses show that the privilege bit and the transfer type each gate the error on their own. A seeded random mix of region, privilege, transfer type and write data is then checked against a bench model of the fields and the visible sizes.

// File: rtl/memlim_pkg.sv
package memlim_pkg;
  localparam int LIM_W   = 3;
  localparam int FL_LSB  = 20;
  localparam int RAM_LSB = 16;

  typedef struct packed {
    logic [LIM_W-1:0] fl;
    logic [LIM_W-1:0] ram;
  } lim_t;

  typedef enum logic [1:0] {
    RSP_OK   = 2'd0,
    RSP_ERR1 = 2'd1,
    RSP_ERR2 = 2'd2
  } rsp_state_e;

  function automatic int fld_lsb(input int idx);
    return (idx == 0) ? FL_LSB : RAM_LSB;
  endfunction
endpackage

// File: rtl/memlim_reg.sv
module memlim_reg
  import memlim_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          boot_ld_i,
  input  logic [DW-1:0] boot_word_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output lim_t          lim_o,
  output logic [DW-1:0] rdata_o
);
  localparam int NF = 2;

  for (genvar g = 0; g < NF; g++) begin : gen_fld
    localparam int LSB = fld_lsb(g);
    logic [LIM_W-1:0] q;
    logic [LIM_W-1:0] req;
    assign req = wdata_i[LSB +: LIM_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 q <= '0;
      else if (boot_ld_i)          q <= boot_word_i[LSB +: LIM_W];
      else if (wr_i && (req > q))  q <= req;  // raise only
    end
  end

  assign lim_o.fl  = gen_fld[0].q;
  assign lim_o.ram = gen_fld[1].q;

  always_comb begin
    rdata_o = '0;
    rdata_o[FL_LSB  +: LIM_W] = lim_o.fl;
    rdata_o[RAM_LSB +: LIM_W] = lim_o.ram;
  end
endmodule

// File: rtl/memlim_rgn.sv
module memlim_rgn
  import memlim_pkg::*;
#(
  parameter int              ADDR_W = 32,
  parameter int              AW     = 16,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [LIM_W-1:0]  lim_i,
  output logic              in_o,
  output logic              hid_o
);
  logic [AW:0] vis;

  assign in_o  = (haddr_i[ADDR_W-1:AW] == BASE[ADDR_W-1:AW]);
  assign vis   = {1'b1, {AW{1'b0}}} >> lim_i;
  assign hid_o = in_o && ({1'b0, haddr_i[AW-1:0]} >= vis);
endmodule

// File: rtl/memlim_rsp.sv
module memlim_rsp
  import memlim_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic hready_o,
  output logic hresp_o
);
  rsp_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RSP_OK:   if (start_i) st_d = RSP_ERR1;
      RSP_ERR1: st_d = RSP_ERR2;
      RSP_ERR2: st_d = start_i ? RSP_ERR1 : RSP_OK;
      default:  st_d = RSP_OK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= RSP_OK;
    else         st_q <= st_d;
  end

  assign hready_o = (st_q != RSP_ERR1);
  assign hresp_o  = (st_q != RSP_OK);
endmodule

// File: rtl/memlim_gate.sv
module memlim_gate
  import memlim_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DW        = 32,
  parameter int          FL_AW     = 16,
  parameter logic [31:0] FL_BASE   = 32'h0000_0000,
  parameter int          RAM_AW    = 13,
  parameter logic [31:0] RAM_BASE  = 32'h2000_0000,
  parameter logic [31:0] LIM_ADDR  = 32'h4010_001C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boot_ld_i,
  input  logic [DW-1:0]     boot_word_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic              hpriv_i,
  input  logic [DW-1:0]     hwdata_i,
  input  logic              hready_i,
  output logic              hready_o,
  output logic              hresp_o,
  output logic [DW-1:0]     hrdata_o,
  output logic              pass_o
);
  lim_t          lim;
  logic [DW-1:0] lim_rdata;
  logic          fl_in, fl_hid, ram_in, ram_hid;
  logic          acc, reg_hit, bad;
  logic          wr_pend_q, rd_pend_q;

  memlim_rgn #(.ADDR_W(ADDR_W), .AW(FL_AW), .BASE(FL_BASE[ADDR_W-1:0])) u_fl_rgn (
    .haddr_i(haddr_i), .lim_i(lim.fl), .in_o(fl_in), .hid_o(fl_hid)
  );

  memlim_rgn #(.ADDR_W(ADDR_W), .AW(RAM_AW), .BASE(RAM_BASE[ADDR_W-1:0])) u_ram_rgn (
    .haddr_i(haddr_i), .lim_i(lim.ram), .in_o(ram_in), .hid_o(ram_hid)
  );

  // only NONSEQ/SEQ taken while the bus is ready are checked
  assign acc     = hready_i && htrans_i[1];
  assign reg_hit = (haddr_i[ADDR_W-1:2] == LIM_ADDR[ADDR_W-1:2]);
  assign bad     = acc && (fl_hid || ram_hid || (reg_hit && !hpriv_i));
  assign pass_o  = htrans_i[1] && ((fl_in && !fl_hid) || (ram_in && !ram_hid));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_pend_q <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      wr_pend_q <= acc && reg_hit && hpriv_i && hwrite_i;
      rd_pend_q <= acc && reg_hit && hpriv_i && !hwrite_i;
    end
  end

  memlim_reg #(.DW(DW)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .boot_ld_i(boot_ld_i), .boot_word_i(boot_word_i),
    .wr_i(wr_pend_q), .wdata_i(hwdata_i),
    .lim_o(lim), .rdata_o(lim_rdata)
  );

  memlim_rsp u_rsp (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(bad),
    .hready_o(hready_o), .hresp_o(hresp_o)
  );

  assign hrdata_o = rd_pend_q ? lim_rdata : '0;
endmodule

// File: rtl/memlim_gate_chk.sv
module memlim_gate_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       boot_ld_i,
  input logic       hready_i,
  input logic [1:0] htrans_i,
  input logic       hpriv_i,
  input logic       hready_o,
  input logic       hresp_o,
  input logic [2:0] fl_lim,
  input logic [2:0] ram_lim,
  input logic       fl_hid,
  input logic       ram_hid,
  input logic       reg_hit
);
  assert_fl_mono_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_ld_i |=> fl_lim >= $past(fl_lim));

  assert_ram_mono_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_ld_i |=> ram_lim >= $past(ram_lim));

  assert_err_second_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_o |=> hready_o && hresp_o);

  assert_wait_has_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_o |-> hresp_o);

  assert_fl_hidden_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hready_i && htrans_i[1] && fl_hid |=> !hready_o && hresp_o);

  assert_ram_hidden_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hready_i && htrans_i[1] && ram_hid |=> !hready_o && hresp_o);

  assert_unpriv_reg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hready_i && htrans_i[1] && reg_hit && !hpriv_i |=> !hready_o && hresp_o);

  assert_idle_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hready_i && !htrans_i[1] |=> !hresp_o);
endmodule

bind memlim_gate memlim_gate_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .boot_ld_i(boot_ld_i),
  .hready_i(hready_i), .htrans_i(htrans_i), .hpriv_i(hpriv_i),
  .hready_o(hready_o), .hresp_o(hresp_o),
  .fl_lim(lim.fl), .ram_lim(lim.ram),
  .fl_hid(fl_hid), .ram_hid(ram_hid), .reg_hit(reg_hit)
);

// File: tb/memlim_gate_bench.sv
module memlim_gate_bench;
  localparam logic [31:0] RAM_BASE = 32'h2000_0000;
  localparam logic [31:0] LIM_ADDR = 32'h4010_001C;
  localparam int          FL_AW    = 16;
  localparam int          RAM_AW   = 13;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        boot_ld_i = 1'b0;
  logic [31:0] boot_word_i = '0;
  logic [31:0] haddr_i = '0;
  logic [1:0]  htrans_i = 2'b00;
  logic        hwrite_i = 1'b0;
  logic        hpriv_i = 1'b0;
  logic [31:0] hwdata_i = '0;
  logic        hready_i;
  logic        hready_o, hresp_o, pass_o;
  logic [31:0] hrdata_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int m_fl = 0;
  int m_ram = 0;

  always #2 clk_i = ~clk_i;
  assign hready_i = hready_o;

  memlim_gate u_memlim_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .boot_ld_i(boot_ld_i), .boot_word_i(boot_word_i),
    .haddr_i(haddr_i), .htrans_i(htrans_i), .hwrite_i(hwrite_i), .hpriv_i(hpriv_i),
    .hwdata_i(hwdata_i), .hready_i(hready_i), .hready_o(hready_o), .hresp_o(hresp_o),
    .hrdata_o(hrdata_o), .pass_o(pass_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_word();
    return (32'(m_fl) << 20) | (32'(m_ram) << 16);
  endfunction

  function automatic bit m_in_fl(input logic [31:0] a);
    return a[31:FL_AW] == '0;
  endfunction
  function automatic bit m_in_ram(input logic [31:0] a);
    return a[31:RAM_AW] == RAM_BASE[31:RAM_AW];
  endfunction
  function automatic bit m_hid(input logic [31:0] a);
    if (m_in_fl(a))  return 32'(a[FL_AW-1:0])  >= (32'd1 << (FL_AW - m_fl));
    if (m_in_ram(a)) return 32'(a[RAM_AW-1:0]) >= (32'd1 << (RAM_AW - m_ram));
    return 1'b0;
  endfunction
  function automatic int m_code(input logic [31:0] a, input bit p, input logic [1:0] tr);
    if (!tr[1]) return 0;
    if (a[31:2] == LIM_ADDR[31:2]) return p ? 0 : 1;
    return m_hid(a) ? 1 : 0;
  endfunction
  function automatic bit m_pass(input logic [31:0] a, input logic [1:0] tr);
    return tr[1] && (m_in_fl(a) || m_in_ram(a)) && !m_hid(a);
  endfunction

  // code: 0 clean, 1 two-cycle error, 2 malformed
  task automatic xfer(input logic [31:0] a, input logic w, input logic [31:0] wd,
                      input logic p, input logic [1:0] tr,
                      output int code, output logic [31:0] rd, output logic ps);
    logic r1, e1, r2, e2;
    @(negedge clk_i);
    haddr_i = a; hwrite_i = w; hpriv_i = p; htrans_i = tr;
    #1 ps = pass_o;
    @(negedge clk_i);
    htrans_i = 2'b00; hwdata_i = wd;
    r1 = hready_o; e1 = hresp_o; rd = hrdata_o;
    @(negedge clk_i);
    r2 = hready_o; e2 = hresp_o;
    if (r1 && !e1 && r2 && !e2)      code = 0;
    else if (!r1 && e1 && r2 && e2)  code = 1;
    else                             code = 2;
  endtask

  // one transfer checked against the model, model updated on accepted writes
  task automatic step(input logic [31:0] a, input logic w, input logic [31:0] wd,
                      input logic p, input logic [1:0] tr, input string req);
    int code, ecode;
    logic [31:0] rd;
    logic ps;
    bit  eps;
    ecode = m_code(a, p, tr);
    eps   = m_pass(a, tr);
    xfer(a, w, wd, p, tr, code, rd, ps);
    chk(code == ecode, {req, " resp"}, 32'(code), 32'(ecode));
    chk(ps == eps, {req, " pass"}, 32'(ps), 32'(eps));
    if (tr[1] && p && a[31:2] == LIM_ADDR[31:2]) begin
      if (!w) chk(rd == m_word(), {req, " rdata"}, rd, m_word());
      else begin
        if (int'(wd[22:20]) > m_fl)  m_fl  = int'(wd[22:20]);
        if (int'(wd[18:16]) > m_ram) m_ram = int'(wd[18:16]);
      end
    end
  endtask

  task automatic rd_lim(input string req);
    step(LIM_ADDR, 1'b0, '0, 1'b1, 2'b10, req);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(hready_o && !hresp_o, "R1 idle resp", {hready_o, hresp_o}, 32'h2);

    // R1: full exposure after reset, register zero
    rd_lim("R1 R7 reset value");
    step(32'h0000_FFFC, 1'b0, '0, 1'b0, 2'b10, "R1 R4 flash top");
    step(RAM_BASE | 32'h1FFC, 1'b1, '0, 1'b0, 2'b10, "R1 R5 ram top");

    // R2: boot load, junk in other bits; flash=1 ram=2
    @(negedge clk_i);
    boot_ld_i = 1'b1; boot_word_i = 32'hFF9A_FFFF;
    @(negedge clk_i);
    boot_ld_i = 1'b0;
    m_fl = 1; m_ram = 2;
    rd_lim("R2 R7 boot value");

    // R4/R5 boundaries
    step(32'h0000_7FFC, 1'b0, '0, 1'b0, 2'b10, "R4 below edge");
    step(32'h0000_8000, 1'b0, '0, 1'b1, 2'b10, "R4 R8 at edge");
    step(RAM_BASE | 32'h07FC, 1'b0, '0, 1'b0, 2'b11, "R5 below edge");
    step(RAM_BASE | 32'h0800, 1'b1, '0, 1'b1, 2'b11, "R5 R8 at edge");

    // R6: unprivileged register access refused and harmless
    step(LIM_ADDR, 1'b0, '0, 1'b0, 2'b10, "R6 unpriv read");
    step(LIM_ADDR, 1'b1, 32'h0077_0000, 1'b0, 2'b10, "R6 unpriv write");
    rd_lim("R6 unchanged");

    // R3: flash raised, lower RAM value ignored
    step(LIM_ADDR, 1'b1, 32'h0030_0000, 1'b1, 2'b10, "R3 raise flash");
    rd_lim("R3 flash only");
    // R3: lower flash ignored, RAM raised, reserved bits dropped
    step(LIM_ADDR, 1'b1, 32'hFF8D_FFFF, 1'b1, 2'b10, "R3 raise ram");
    rd_lim("R3 R7 ram only");
    step(32'h0000_1FFC, 1'b0, '0, 1'b0, 2'b10, "R4 n3 below");
    step(32'h0000_2000, 1'b0, '0, 1'b0, 2'b10, "R4 n3 at edge");
    step(RAM_BASE | 32'h00FC, 1'b0, '0, 1'b0, 2'b10, "R5 n5 below");
    step(RAM_BASE | 32'h0100, 1'b0, '0, 1'b0, 2'b10, "R5 n5 at edge");

    // R9: IDLE/BUSY to hidden or locked space
    step(32'h0000_F000, 1'b0, '0, 1'b0, 2'b00, "R9 idle hidden");
    step(32'h0000_F000, 1'b1, '0, 1'b0, 2'b01, "R9 busy hidden");
    step(LIM_ADDR, 1'b0, '0, 1'b0, 2'b01, "R9 busy unpriv reg");
    step(32'h0000_F000, 1'b0, '0, 1'b0, 2'b11, "R9 R8 seq hidden");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, wd;
      int k;
      k = $urandom_range(0, 4);
      wd = $urandom();
      if ($urandom_range(0, 3) != 0) wd[22:20] = 3'($urandom_range(0, 2) + m_fl / 2);
      case (k)
        0:       a = {16'h0, 16'($urandom()) & 16'hFFFC};
        1:       a = RAM_BASE | (32'($urandom()) & 32'h1FFC);
        2:       a = LIM_ADDR;
        3:       a = 32'h5000_0000 | (32'($urandom()) & 32'hFFFC);
        default: a = {16'h0, 16'($urandom_range(0, 255)) << 2};
      endcase
      step(a, 1'($urandom()), wd, 1'($urandom()), 2'($urandom()),
           "R3 R4 R5 R6 R8 R9 random");
    end
    rd_lim("R3 R7 final");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule